// File: doc/BRIEF.md
# Multiplexed-Bus Byte-Enable Slave Agent

This block is a slave on a 32-bit multiplexed address/data bus. An address cycle carries the word address, the direction, a burst count and the byte enables for the first data word. The data cycles that follow move one word each time the agent raises READY. The agent counts a captured number of wait cycles before each READY. It steps the word address by one after every READY, and it serves reads and byte-masked writes from a small internal register file.

Byte enables run one word ahead of the data. The enables sampled in the address cycle cover the first word. The enables sampled in the READY cycle of a word cover the word after it. The agent finds the low two address bits from the lowest asserted enable and checks every captured pattern. In the cycle after the final READY it pulses a bad-access strobe if any pattern was illegal or if the burst ran past the end of the register file.

Top module: `mbs_slave`

## Requirements
- R1: In an idle cycle with `addr_phase` high, the agent captures the word address from `bus_ad_in[31:2]`. During the first word, `xfer_addr[31:2]` equals that captured value.
- R2: `be_n` is active low, and bit i enables data bits 8i+7:8i. `xfer_addr[1:0]` is the index of the lowest enabled byte of the current word, or 0 when no byte is enabled.
- R3: The first word uses the enables from the address cycle. Every later word uses the enables sampled in the READY cycle of the word before it. Enables in wait cycles, and in any data cycle of the last word, have no effect.
- R4: With W = `wait_cfg` captured in the address cycle, READY is high in the (W+1)-th data cycle of each word and low in the W cycles before it. Changes to `wait_cfg` during a transaction have no effect.
- R5: A transaction moves `burst_len`+1 words (`burst_len` captured in the address cycle). The word address steps by one after each READY, and READY stays low once the last word is done.
- R6: On a write, only the enabled bytes of the addressed register take `bus_ad_in` at READY. On a read, `rd_data` carries the full 32-bit register during READY and is zero in every other cycle.
- R7: A pattern is legal when at least one enable is asserted and all asserted enables are adjacent. A write word with an illegal pattern leaves the register unchanged.
- R8: A word whose index is DEPTH (16) or above is out of range. A write to it is dropped and a read of it returns zero.
- R9: `bad_acc` is high for exactly the one cycle after the last READY, and only if some word of the transaction had an illegal pattern or was out of range. It is low in every other cycle.
- R10: `addr_phase`, `cyc_write` and `burst_len` have no effect while a transaction is in progress.
- R11: After reset, READY and `bad_acc` are low and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ad_in | input | 32 | Address in the address cycle, write data in data cycles |
| addr_phase | input | 1 | High marks an address cycle |
| cyc_write | input | 1 | Direction in the address cycle: 1 write, 0 read |
| burst_len | input | 2 | Words minus one, captured in the address cycle |
| wait_cfg | input | 2 | Wait cycles before each READY, captured in the address cycle |
| be_n | input | 4 | Active-low byte enables, one word ahead of data |
| rdy | output | 1 | READY: the current word completes this cycle |
| bad_acc | output | 1 | Bad-access strobe, one cycle after the last READY |
| rd_data | output | 32 | Read data during READY of a read, else zero |
| xfer_addr | output | 32 | Byte address of the current word |

## Verification
Two events can land in the same cycle: the bad-access strobe of one transaction and the address cycle of the next, because the agent is idle again right after its last READY. The bench provokes this by starting a new transaction in the very cycle after a failing burst. In that cycle it checks that `bad_acc` reports the earlier burst. It then checks that the new burst captures its own address, enables and wait count cleanly, and that its own strobe later reflects only its own words. Bursts that drive junk on `addr_phase`, `burst_len`, `wait_cfg` and the enables in non-sampled cycles check that these inputs are ignored mid-transaction.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int BE_W = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DATA = 1'b1
    } mbs_state_e;

    // active-high enables: nonempty and one contiguous run
    function automatic logic be_is_legal(input logic [BE_W-1:0] be);
        logic [BE_W-1:0] lsb;
        lsb = be & (~be + 1'b1);
        return (be != '0) && (((be + lsb) & be) == '0);
    endfunction

endpackage

// File: rtl/mbs_be_decode.sv
module mbs_be_decode
    import mbs_pkg::*;
(
    input  logic [BE_W-1:0] be,
    output logic            legal,
    output logic [1:0]      lo_bits
);

    always_comb begin
        lo_bits = 2'd0;
        for (int i = BE_W - 1; i >= 0; i--) begin
            if (be[i]) lo_bits = 2'(i);
        end
    end

    assign legal = be_is_legal(be);

endmodule

// File: rtl/mbs_regfile.sv
module mbs_regfile
    import mbs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [BE_W-1:0]  wbe,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);

    logic [31:0] mem_q [DEPTH];

    for (genvar r = 0; r < DEPTH; r++) begin : g_row
        for (genvar b = 0; b < BE_W; b++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[r][8*b +: 8] <= 8'h00;
                end else if (we && (idx == IDX_W'(r)) && wbe[b]) begin
                    mem_q[r][8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    end

    assign rdata = mem_q[idx];

    // R6: a write strobe always carries at least one byte lane
    a_r6_we_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (wbe != '0));

endmodule

// File: rtl/mbs_slave.sv
module mbs_slave
    import mbs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int WA_W  = 30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bus_ad_in,
    input  logic        addr_phase,
    input  logic        cyc_write,
    input  logic [1:0]  burst_len,
    input  logic [1:0]  wait_cfg,
    input  logic [3:0]  be_n,
    output logic        rdy,
    output logic        bad_acc,
    output logic [31:0] rd_data,
    output logic [31:0] xfer_addr
);

    localparam logic [WA_W-1:0] LIMIT = WA_W'(DEPTH);

    typedef struct packed {
        mbs_state_e      st;
        logic            wr;
        logic [1:0]      left;
        logic [1:0]      wt;
        logic [1:0]      wcnt;
        logic [WA_W-1:0] wa;
        logic [BE_W-1:0] be;
        logic            err;
        logic            bad;
    } ctl_t;

    ctl_t q, d;

    logic        cur_legal;
    logic [1:0]  cur_lo;
    logic        in_range;
    logic        err_nx;
    logic        rf_we;
    logic [31:0] rf_rd;
    wire  [1:0]  unused_lo = bus_ad_in[1:0];

    mbs_be_decode u_dec (
        .be      (q.be),
        .legal   (cur_legal),
        .lo_bits (cur_lo)
    );

    assign in_range = (q.wa < LIMIT);
    assign rdy      = (q.st == ST_DATA) && (q.wcnt == q.wt);
    assign err_nx   = q.err | ~cur_legal | ~in_range;
    assign rf_we    = rdy && q.wr && cur_legal && in_range;

    mbs_regfile #(.DEPTH(DEPTH)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .idx   (q.wa[IDX_W-1:0]),
        .wbe   (q.be),
        .wdata (bus_ad_in),
        .rdata (rf_rd)
    );

    always_comb begin
        d     = q;
        d.bad = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (addr_phase) begin
                    d.st   = ST_DATA;
                    d.wa   = bus_ad_in[31:2];
                    d.be   = ~be_n;
                    d.wr   = cyc_write;
                    d.left = burst_len;
                    d.wt   = wait_cfg;
                    d.wcnt = 2'd0;
                    d.err  = 1'b0;
                end
            end
            ST_DATA: begin
                if (!rdy) begin
                    d.wcnt = q.wcnt + 2'd1;
                end else if (q.left == 2'd0) begin
                    d.st  = ST_IDLE;
                    d.bad = err_nx;
                    d.err = 1'b0;
                end else begin
                    d.left = q.left - 2'd1;
                    d.wa   = q.wa + WA_W'(1);
                    d.be   = ~be_n;
                    d.wcnt = 2'd0;
                    d.err  = err_nx;
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign bad_acc   = q.bad;
    assign xfer_addr = {q.wa, cur_lo};
    assign rd_data   = (rdy && !q.wr && in_range) ? rf_rd : 32'h0;

    // R3: latched enables hold through wait cycles
    a_r3_be_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA && !rdy) |=> $stable(q.be));

    // R4: back-to-back READY only with zero wait cycles
    a_r4_wait_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && q.wt != 2'd0) |=> !rdy);

    // R5: word address steps by one between words of a burst
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && q.left != 2'd0) |=> (q.wa == $past(q.wa) + WA_W'(1)));

    // R9: strobe only in the cycle right after a READY
    a_r9_bad_after_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        bad_acc |-> ($past(rdy) && !rdy));

    // R10: an address cycle during a burst leaves the state unchanged
    a_r10_no_recapture: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA && !rdy) |=> ($stable(q.wa) && $stable(q.left)));

endmodule

// File: tb/mbs_slave_tb.sv
`timescale 1ns/1ps
module mbs_slave_tb;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [1:0]  len;
        logic [1:0]  wt;
        logic [15:0] bes;
        logic        junk;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0000_0000, 2'd3, 2'd0, 16'hFFFF, 1'b0},
        '{1'b0, 32'h0000_0000, 2'd3, 2'd1, 16'hFFFF, 1'b1},
        '{1'b1, 32'h0000_0010, 2'd1, 2'd2, 16'h00C3, 1'b0},
        '{1'b0, 32'h0000_0010, 2'd1, 2'd0, 16'h00FF, 1'b0},
        '{1'b1, 32'h0000_0020, 2'd0, 2'd3, 16'h0005, 1'b0},
        '{1'b0, 32'h0000_0020, 2'd0, 2'd0, 16'h000F, 1'b0},
        '{1'b1, 32'h0000_0034, 2'd3, 2'd0, 16'hFFFF, 1'b1},
        '{1'b0, 32'h0000_0034, 2'd2, 2'd1, 16'h0FFF, 1'b0},
        '{1'b0, 32'h0000_003C, 2'd1, 2'd0, 16'h00FF, 1'b1},
        '{1'b1, 32'h0000_0008, 2'd2, 2'd0, 16'h0861, 1'b0},
        '{1'b0, 32'h0000_0008, 2'd2, 2'd1, 16'h0FF0, 1'b0},
        '{1'b1, 32'h0000_0004, 2'd0, 2'd0, 16'h000E, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_ad_in = '0;
    logic        addr_phase = 1'b0;
    logic        cyc_write = 1'b0;
    logic [1:0]  burst_len = '0;
    logic [1:0]  wait_cfg = '0;
    logic [3:0]  be_n = 4'hF;
    logic        rdy, bad_acc;
    logic [31:0] rd_data, xfer_addr;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic        pend_bad = 1'b0;
    logic [31:0] mdl [16];
    bit          done = 1'b0;

    always #10 clk = ~clk;

    mbs_slave u_dut (
        .clk(clk), .rst_n(rst_n), .bus_ad_in(bus_ad_in), .addr_phase(addr_phase),
        .cyc_write(cyc_write), .burst_len(burst_len), .wait_cfg(wait_cfg),
        .be_n(be_n), .rdy(rdy), .bad_acc(bad_acc), .rd_data(rd_data),
        .xfer_addr(xfer_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit b_legal(input logic [3:0] be);
        int runs = 0;
        for (int i = 0; i < 4; i++) begin
            if (be[i] && (i == 0 || !be[i-1])) runs++;
        end
        return runs == 1;
    endfunction

    function automatic logic [1:0] b_low(input logic [3:0] be);
        logic [1:0] lo = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (be[i]) lo = 2'(i);
        end
        return lo;
    endfunction

    task automatic do_txn(input vec_t v, input int tag);
        logic        exp_bad = 1'b0;
        logic [29:0] wa;
        logic [3:0]  be;
        logic [31:0] dat;
        logic [31:0] exp_rd;
        @(negedge clk);
        addr_phase = 1'b1;
        bus_ad_in  = v.addr;
        cyc_write  = v.wr;
        burst_len  = v.len;
        wait_cfg   = v.wt;
        be_n       = ~v.bes[3:0];
        #1;
        chk("R9 strobe in address cycle", {31'd0, bad_acc}, {31'd0, pend_bad});
        pend_bad = 1'b0;
        for (int w = 0; w <= int'(v.len); w++) begin
            wa  = v.addr[31:2] + 30'(w);
            be  = v.bes[w*4 +: 4];
            dat = 32'h5A00_0000 ^ (32'(tag) << 12) ^ (32'(w) * 32'h0102_0304);
            if (!b_legal(be) || wa >= 30'd16) exp_bad = 1'b1;
            for (int c = 0; c <= int'(v.wt); c++) begin
                @(negedge clk);
                addr_phase = v.junk;
                cyc_write  = v.junk ? ~v.wr : v.wr;
                burst_len  = ~v.len;
                wait_cfg   = 2'd3 - v.wt;
                bus_ad_in  = v.wr ? dat : 32'hDEAD_BEEF;
                be_n = (c == int'(v.wt) && w < int'(v.len)) ? ~v.bes[(w+1)*4 +: 4] : 4'b1010;
                #1;
                chk(v.junk ? "R4/R10 ready timing" : "R4 ready timing",
                    {31'd0, rdy}, {31'd0, (c == int'(v.wt))});
                if (c == int'(v.wt)) begin
                    chk("R1/R2/R3 transfer address", xfer_addr, {wa, b_low(be)});
                    if (v.wr) begin
                        chk("R6 read data idle on write", rd_data, 32'h0);
                        if (b_legal(be) && wa < 30'd16) begin
                            for (int b = 0; b < 4; b++) begin
                                if (be[b]) mdl[wa[3:0]][8*b +: 8] = dat[8*b +: 8];
                            end
                        end
                    end else begin
                        exp_rd = (wa < 30'd16) ? mdl[wa[3:0]] : 32'h0;
                        chk("R6/R7/R8 read word", rd_data, exp_rd);
                    end
                end else begin
                    chk("R6 read data zero in wait", rd_data, 32'h0);
                end
            end
        end
        pend_bad = exp_bad;
    endtask

    task automatic idle_cyc();
        @(negedge clk);
        addr_phase = 1'b0;
        be_n       = 4'hF;
        bus_ad_in  = '0;
        #1;
        chk("R9 strobe after last ready", {31'd0, bad_acc}, {31'd0, pend_bad});
        chk("R5 no ready after burst", {31'd0, rdy}, 32'd0);
        pend_bad = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        pend_bad = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        do_reset();
        #1;
        chk("R11 ready low after reset", {31'd0, rdy}, 32'd0);
        chk("R11 strobe low after reset", {31'd0, bad_acc}, 32'd0);
        chk("R11 read data low after reset", rd_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_txn(VECS[i], i);
            idle_cyc();
        end

        // R9: failing burst, then a new address cycle in its strobe cycle
        do_txn('{1'b1, 32'h0000_0030, 2'd1, 2'd0, 16'h0029, 1'b0}, 20);
        do_txn('{1'b0, 32'h0000_0030, 2'd1, 2'd1, 16'h0031, 1'b0}, 21);
        do_txn('{1'b0, 32'h0000_0000, 2'd0, 2'd2, 16'h000F, 1'b0}, 22);
        idle_cyc();

        // R11: registers cleared by reset
        do_txn('{1'b1, 32'h0000_0014, 2'd0, 2'd0, 16'h000F, 1'b0}, 30);
        idle_cyc();
        do_reset();
        do_txn('{1'b0, 32'h0000_0014, 2'd0, 2'd0, 16'h000F, 1'b0}, 31);
        idle_cyc();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule